// File: doc/BRIEF.md
# Flash Power-State and Reset Controller

This controller sits beside the array of a parallel NOR-style flash model and decides, every clock, which power state the device is in and whether its data pins may be driven. It watches the active-low chip-enable, output-enable and write-enable pins, an active-low device reset pin, the address bus, a flag that selects synchronous (burst) or asynchronous reads, and a busy flag from the embedded program/erase engine.

From these it produces a two-bit power state, an output-drive enable for the data pads, a hold signal that freezes the data latch while the device sleeps, and one-cycle pulses that clear the configuration register and abort the running program/erase operation. It also produces a gate that lets the command decoder accept a write cycle. Every time threshold (chip-enable access time, address-access time plus the sleep margin, minimum reset pulse width) is given in nanoseconds as a parameter. It is turned into whole clock cycles by rounding up.

The state is registered, and one clock edge decides each transition. The drive enable and command gate combine the registered state with the live pin levels.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: The power state is encoded on `pwr_state` as 0 = active, 1 = standby, 2 = auto-sleep, 3 = reset. The state after `rst_n` is standby. With the device reset pin high, chip enable high and the engine idle, the next clock edge selects standby. In standby `out_drive` is 0 whatever `out_en_n` is.
- R2: With chip enable high while `engine_busy` is 1, the state stays active. The first clock edge that samples `engine_busy` low moves it to standby.
- R3: `out_drive` stays 0 until CE_CYC clock edges have passed outside standby and reset, counting the edge that left them. CE_CYC is the chip-enable access time divided by the clock period, rounded up.
- R4: In asynchronous mode, with the device selected, the state becomes auto-sleep on the SLEEP_CYC-th edge after the last address change. SLEEP_CYC is the address access time plus the margin, over the clock period, rounded up. Output enable and write enable have no influence on entering or staying in sleep.
- R5: In auto-sleep `data_hold` is 1 and `out_drive` still follows output enable. The first edge that samples an address different from the previous one returns the state to active, and `data_hold` falls.
- R6: While `sync_mode` is 1 the state never becomes auto-sleep. A sleeping device returns to active on the first edge that samples `sync_mode` high.
- R7: When the device reset pin has been sampled low on RST_CYC consecutive edges, the state is reset. RST_CYC is the minimum pulse width over the clock period, rounded up. In the reset state `out_drive` is 0.
- R8: On entry into the reset state, `op_abort` and `cfg_clear` are 1 for exactly one clock cycle.
- R9: `cmd_gate` is 1 only when the reset pin is high, the state is not reset, and both chip enable and write enable are low.
- R10: The first edge that samples the reset pin high leaves the reset state for active if chip enable is low, or for standby if it is high.
- R11: A reset pin low for fewer than RST_CYC edges leaves the power state unchanged and raises no abort or clear pulse.
- R12: A qualifying reset takes the state to reset even while the engine is busy or the device is asleep.
- R13: The address-stability count restarts on every address change. It saturates at its threshold, so a device left with a stable address stays asleep indefinitely.
- R14: With output enable high, `out_drive` is 0 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Controller reset, active low |
| chip_en_n | input | 1 | Device chip enable, active low |
| out_en_n | input | 1 | Device output enable, active low |
| wr_en_n | input | 1 | Device write enable, active low |
| dev_rst_n | input | 1 | Device hardware reset pin, active low |
| addr | input | ADDR_W | Device address bus |
| sync_mode | input | 1 | 1 = synchronous burst reads, 0 = asynchronous |
| engine_busy | input | 1 | Program/erase engine running |
| pwr_state | output | 2 | Power state (0 active, 1 standby, 2 sleep, 3 reset) |
| out_drive | output | 1 | Enable for the data output drivers |
| data_hold | output | 1 | Freeze the output data latch |
| cfg_clear | output | 1 | One-cycle configuration-register clear |
| cmd_gate | output | 1 | Command decoder may accept this write cycle |
| op_abort | output | 1 | One-cycle abort of the running program/erase |

## Verification
The assertions check these rules on every cycle:
- outputs stay undriven in standby and reset;
- the command gate stays closed while the reset pin is low;
- the abort pulse is a single cycle and appears only on entry to reset;
- a busy engine holds a deselected device active;
- sleep is never entered from synchronous mode;
- a qualifying reset always wins;
- the stability and reset-width counters stay bounded.

The exact cycle on which sleep, readiness after standby or reset, and reset entry occur depends on counted history. Only the bench's scenarios show those timings, by comparing against a cycle-by-cycle model. They also show that a short reset leaves the state untouched and that output enable and write enable toggled during sleep do not disturb it.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_SLEEP   = 2'd2,
    PS_RESET   = 2'd3
  } pwr_state_e;

  // Whole clock cycles covering a duration in ns, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned dur_ns,
                                            input int unsigned clk_ns);
    int unsigned c;
    c = (dur_ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Counter width able to hold values 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    if (max_val < 2) return 1;
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/fpc_rst_filter.sv
// Qualifies the device reset pin: counts consecutive low samples and
// reports when this edge completes the minimum pulse width.
module fpc_rst_filter #(
  parameter int unsigned MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_rst_n,
  output logic rst_take
);
  localparam int unsigned CW = flash_pwr_pkg::cnt_width(MIN_LOW);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW);
  localparam logic [CW-1:0] ARM = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_q <= '0;
    else if (dev_rst_n)  low_q <= '0;
    else if (low_q != LIM) low_q <= low_q + 1'b1;
  end

  // Low at this edge and enough earlier low edges: reset qualifies now.
  assign rst_take = !dev_rst_n && (low_q >= ARM);

  a_r11_low_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    low_q <= LIM);

  generate
    if (MIN_LOW > 1) begin : g_hist
      a_r11_take_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        rst_take |-> (low_q != '0));
    end
  endgenerate

endmodule

// File: rtl/fpc_addr_watch.sv
// Tracks how long the address bus has stayed unchanged.
module fpc_addr_watch #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned STABLE_CYC = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_moved,
  output logic              stable_take
);
  localparam int unsigned CW = flash_pwr_pkg::cnt_width(STABLE_CYC);
  localparam logic [CW-1:0] LIM = CW'(STABLE_CYC);
  localparam logic [CW-1:0] ARM = CW'(STABLE_CYC - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     cnt_q;

  assign addr_moved = (addr != addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr;
      if (addr_moved)        cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  // This edge reaches the stability threshold (or it was already reached).
  assign stable_take = !addr_moved && (cnt_q >= ARM);

  a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  a_r13_restart_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    addr_moved |=> (cnt_q == '0));

endmodule

// File: rtl/fpc_access_timer.sv
// Counts edges spent outside standby/reset; reads are valid once it saturates.
module fpc_access_timer #(
  parameter int unsigned ACC_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ready
);
  localparam int unsigned CW = flash_pwr_pkg::cnt_width(ACC_CYC);
  localparam logic [CW-1:0] LIM = CW'(ACC_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (restart)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == LIM);

  a_r3_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !restart) |=> ready);

  a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ready);

endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import flash_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W          = 16,
  parameter int unsigned CLK_NS          = 10,
  parameter int unsigned ACC_NS          = 70,
  parameter int unsigned SLEEP_MARGIN_NS = 20,
  parameter int unsigned CE_ACC_NS       = 70,
  parameter int unsigned RST_MIN_NS      = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic              dev_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sync_mode,
  input  logic              engine_busy,
  output logic [1:0]        pwr_state,
  output logic              out_drive,
  output logic              data_hold,
  output logic              cfg_clear,
  output logic              cmd_gate,
  output logic              op_abort
);
  localparam int unsigned SLEEP_CYC = ns_to_cyc(ACC_NS + SLEEP_MARGIN_NS, CLK_NS);
  localparam int unsigned CE_CYC    = ns_to_cyc(CE_ACC_NS, CLK_NS);
  localparam int unsigned RST_CYC   = ns_to_cyc(RST_MIN_NS, CLK_NS);

  // Internal events, named for the assertions.
  logic rst_take;
  logic addr_moved;
  logic stable_take;
  logic acc_ready;
  logic acc_restart;
  logic selected;
  logic reset_entry;

  pwr_state_e st_q, st_d;
  logic       pulse_q;

  assign selected = !chip_en_n;

  fpc_rst_filter #(.MIN_LOW(RST_CYC)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_rst_n (dev_rst_n),
    .rst_take  (rst_take)
  );

  fpc_addr_watch #(.ADDR_W(ADDR_W), .STABLE_CYC(SLEEP_CYC)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .addr_moved  (addr_moved),
    .stable_take (stable_take)
  );

  // Priority: qualified reset, short-reset hold, deselect (busy hold / standby),
  // then auto-sleep in asynchronous mode, else active.
  always_comb begin
    if (rst_take)                       st_d = PS_RESET;
    else if (!dev_rst_n)                st_d = st_q;
    else if (!selected)                 st_d = engine_busy ? PS_ACTIVE : PS_STANDBY;
    else if (!sync_mode && stable_take) st_d = PS_SLEEP;
    else                                st_d = PS_ACTIVE;
  end

  assign acc_restart = (st_d == PS_STANDBY) || (st_d == PS_RESET);
  assign reset_entry = (st_d == PS_RESET) && (st_q != PS_RESET);

  fpc_access_timer #(.ACC_CYC(CE_CYC)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (acc_restart),
    .ready   (acc_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_STANDBY;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= reset_entry;
    end
  end

  assign pwr_state = st_q;
  assign data_hold = (st_q == PS_SLEEP);
  assign out_drive = ((st_q == PS_ACTIVE) || (st_q == PS_SLEEP)) &&
                     selected && !out_en_n && acc_ready;
  assign cmd_gate  = dev_rst_n && (st_q != PS_RESET) && selected && !wr_en_n;
  assign op_abort  = pulse_q;
  assign cfg_clear = pulse_q;

  a_r1_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_STANDBY) |-> !out_drive);

  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_ACTIVE) && engine_busy && chip_en_n && dev_rst_n) |=> (st_q == PS_ACTIVE));

  a_r5_wake_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_SLEEP) && addr_moved && dev_rst_n && selected) |=> (st_q == PS_ACTIVE));

  a_r6_no_sync_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SLEEP) |-> !$past(sync_mode));

  a_r7_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RESET) |-> (!out_drive && !cmd_gate));

  a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |=> !op_abort);

  a_r8_abort_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |-> (st_q == PS_RESET));

  a_r9_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |-> !cmd_gate);

  a_r11_no_spurious_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != PS_RESET) && !rst_take) |=> (st_q != PS_RESET));

  a_r12_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take |=> (st_q == PS_RESET));

  a_r14_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !out_drive);

endmodule

// File: tb/flash_pwr_ctrl_tb_top.sv
module flash_pwr_ctrl_tb_top;
  localparam int CLK_P   = 10;
  localparam int AW      = 8;
  localparam int T_CLK   = 10;
  localparam int T_ACC   = 70;
  localparam int T_MARG  = 20;
  localparam int T_CE    = 70;
  localparam int T_RP    = 30;
  localparam int SLEEP_N = (T_ACC + T_MARG + T_CLK - 1) / T_CLK;
  localparam int CE_N    = (T_CE + T_CLK - 1) / T_CLK;
  localparam int RP_N    = (T_RP + T_CLK - 1) / T_CLK;

  logic clk = 1'b0;
  logic rst_n, chip_en_n, out_en_n, wr_en_n, dev_rst_n, sync_mode, engine_busy;
  logic [AW-1:0] addr;
  logic [1:0] pwr_state;
  logic out_drive, data_hold, cfg_clear, cmd_gate, op_abort;

  always #(CLK_P/2) clk = ~clk;

  flash_pwr_ctrl #(
    .ADDR_W(AW), .CLK_NS(T_CLK), .ACC_NS(T_ACC), .SLEEP_MARGIN_NS(T_MARG),
    .CE_ACC_NS(T_CE), .RST_MIN_NS(T_RP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .dev_rst_n(dev_rst_n), .addr(addr), .sync_mode(sync_mode),
    .engine_busy(engine_busy), .pwr_state(pwr_state), .out_drive(out_drive),
    .data_hold(data_hold), .cfg_clear(cfg_clear), .cmd_gate(cmd_gate),
    .op_abort(op_abort)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit abort_seen = 1'b0;
  string tag = "R1";

  // Behavioural reference: 0 active, 1 standby, 2 sleep, 3 reset.
  int m_state = 1;
  int m_lowrun = 0;
  int m_still = 0;
  int m_since = 0;
  int m_last_addr = 0;
  bit m_pulse = 1'b0;

  task automatic check(input string r, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int nxt;
    bit rst_ok, still_ok;
    rst_ok   = !dev_rst_n && (m_lowrun + 1 >= RP_N);
    still_ok = (int'(addr) == m_last_addr) && (m_still + 1 >= SLEEP_N);
    if (rst_ok)                     nxt = 3;
    else if (!dev_rst_n)            nxt = m_state;
    else if (chip_en_n)             nxt = engine_busy ? 0 : 1;
    else if (!sync_mode && still_ok) nxt = 2;
    else                            nxt = 0;
    m_pulse = (nxt == 3) && (m_state != 3);
    m_since = (nxt == 1 || nxt == 3) ? 0 : ((m_since < CE_N) ? m_since + 1 : CE_N);
    m_lowrun = dev_rst_n ? 0 : ((m_lowrun < RP_N) ? m_lowrun + 1 : RP_N);
    if (int'(addr) != m_last_addr) m_still = 0;
    else if (m_still < SLEEP_N)    m_still = m_still + 1;
    m_last_addr = int'(addr);
    m_state = nxt;
  endtask

  function automatic int exp_drive();
    return ((m_state == 0 || m_state == 2) && !chip_en_n && !out_en_n && m_since == CE_N) ? 1 : 0;
  endfunction

  function automatic int exp_gate();
    return (dev_rst_n && m_state != 3 && !chip_en_n && !wr_en_n) ? 1 : 0;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      if (op_abort) abort_seen = 1'b1;
      check(tag, int'(pwr_state), m_state, "state vs model");
      check(tag, int'(out_drive), exp_drive(), "out_drive vs model");
      check(tag, int'(data_hold), (m_state == 2) ? 1 : 0, "data_hold vs model");
      check(tag, int'(op_abort), int'(m_pulse), "op_abort vs model");
      check(tag, int'(cfg_clear), int'(m_pulse), "cfg_clear vs model");
      check(tag, int'(cmd_gate), exp_gate(), "cmd_gate vs model");
    end
  endtask

  initial begin
    rst_n = 1'b0; chip_en_n = 1'b1; out_en_n = 1'b0; wr_en_n = 1'b1;
    dev_rst_n = 1'b1; sync_mode = 1'b0; engine_busy = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", int'(pwr_state), 1, "state after reset");
    check("R1", int'(out_drive), 0, "drive after reset");
    check("R8", int'(op_abort), 0, "abort after reset");
    check("R9", int'(cmd_gate), 0, "gate after reset");
    @(negedge clk);

    // R3: access time after leaving standby, addresses moving.
    tag = "R3";
    chip_en_n = 1'b0;
    for (int i = 1; i <= CE_N; i++) begin
      addr = AW'(i);
      step(1);
      check("R3", int'(out_drive), (i == CE_N) ? 1 : 0, "drive during access time");
    end
    // R14: output enable high blocks the drivers.
    tag = "R14";
    out_en_n = 1'b1; addr = 8'h20; step(1);
    check("R14", int'(out_drive), 0, "drive with OE high");
    out_en_n = 1'b0;

    // R4/R5/R13: auto-sleep on stable address.
    tag = "R4";
    addr = 8'h40; step(1);
    step(SLEEP_N - 1);
    check("R4", int'(pwr_state), 0, "state one edge before sleep");
    step(1);
    check("R4", int'(pwr_state), 2, "state at sleep threshold");
    check("R5", int'(data_hold), 1, "hold in sleep");
    check("R5", int'(out_drive), 1, "drive in sleep");
    out_en_n = 1'b1; wr_en_n = 1'b0; step(3);
    check("R4", int'(pwr_state), 2, "sleep with OE/WE toggled");
    check("R14", int'(out_drive), 0, "drive in sleep with OE high");
    out_en_n = 1'b0; wr_en_n = 1'b1;
    tag = "R13";
    step(40);
    check("R13", int'(pwr_state), 2, "long stable address stays asleep");
    tag = "R5";
    addr = 8'h41; step(1);
    check("R5", int'(pwr_state), 0, "wake on address change");
    check("R5", int'(data_hold), 0, "hold released on wake");
    tag = "R13";
    step(SLEEP_N - 3);
    addr = 8'h42; step(1);
    step(SLEEP_N - 1);
    check("R13", int'(pwr_state), 0, "count restarted by change");
    step(1);
    check("R13", int'(pwr_state), 2, "sleep after restarted count");

    // R6: synchronous mode.
    tag = "R6";
    sync_mode = 1'b1; step(1);
    check("R6", int'(pwr_state), 0, "sync mode leaves sleep");
    step(3 * SLEEP_N);
    check("R6", int'(pwr_state), 0, "no sleep in sync mode");
    sync_mode = 1'b0; step(1);
    check("R6", int'(pwr_state), 2, "sleep resumes in async mode");

    // R2/R1: deselect while busy.
    tag = "R2";
    engine_busy = 1'b1; chip_en_n = 1'b1; step(10);
    check("R2", int'(pwr_state), 0, "busy holds active");
    check("R1", int'(out_drive), 0, "deselected drive");
    engine_busy = 1'b0; step(1);
    check("R2", int'(pwr_state), 1, "standby after busy ends");
    check("R1", int'(out_drive), 0, "standby drive with OE low");

    // R11/R9: short reset pulse.
    tag = "R11";
    chip_en_n = 1'b0; addr = 8'h50; step(1);
    check("R1", int'(pwr_state), 0, "active after select");
    wr_en_n = 1'b0; step(1);
    check("R9", int'(cmd_gate), 1, "gate open");
    abort_seen = 1'b0;
    dev_rst_n = 1'b0; step(RP_N - 1);
    check("R9", int'(cmd_gate), 0, "gate closed during pulse");
    check("R11", int'(pwr_state), 0, "short pulse state");
    dev_rst_n = 1'b1; step(1);
    check("R11", int'(pwr_state), 0, "state after short pulse");
    check("R11", int'(abort_seen), 0, "no abort from short pulse");
    check("R9", int'(cmd_gate), 1, "gate reopened");

    // R7/R8/R12/R10: full reset while busy.
    tag = "R7";
    engine_busy = 1'b1;
    dev_rst_n = 1'b0; step(RP_N - 1);
    check("R7", int'(pwr_state), 0, "before width reached");
    step(1);
    check("R12", int'(pwr_state), 3, "reset beats busy");
    check("R8", int'(op_abort), 1, "abort pulse");
    check("R8", int'(cfg_clear), 1, "clear pulse");
    check("R7", int'(out_drive), 0, "drive in reset");
    step(1);
    check("R8", int'(op_abort), 0, "abort one cycle");
    check("R8", int'(cfg_clear), 0, "clear one cycle");
    step(5);
    tag = "R10";
    dev_rst_n = 1'b1; engine_busy = 1'b0; addr = 8'h60; step(1);
    check("R10", int'(pwr_state), 0, "release to active");
    check("R3", int'(out_drive), 0, "not ready after release");
    step(CE_N - 2);
    check("R3", int'(out_drive), 0, "one edge before ready");
    step(1);
    check("R3", int'(out_drive), 1, "ready after access time");
    check("R9", int'(cmd_gate), 1, "gate after release");
    wr_en_n = 1'b1;

    // R12: reset from sleep, release to standby.
    tag = "R12";
    step(SLEEP_N);
    check("R4", int'(pwr_state), 2, "asleep before reset");
    dev_rst_n = 1'b0; step(RP_N);
    check("R12", int'(pwr_state), 3, "reset beats sleep");
    chip_en_n = 1'b1; dev_rst_n = 1'b1; step(1);
    check("R10", int'(pwr_state), 1, "release to standby");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule